// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is a small synchronous controller for a machine that sells one item at a price of three units. Buyers insert two kinds of coin: one worth a single unit and one worth two units. Each coin arrives as a one-cycle pulse on its own input. The block keeps a running credit and fires a one-cycle vend strobe once the credit reaches the price. When the final coin carries the total above the price, it also fires a change strobe.

Internally the credit sits in a two-bit binary state register. The next state and the strobes are computed as a Mealy function of the credit and the coin seen this cycle. The strobes are then captured in flip-flops, so that no combinational glitch reaches the outputs. Both coin lines are asynchronous to the clock, so each passes through a synchroniser chain before the decision logic sees it. The fourth code of the state register is never used in normal operation. If the register ever holds it, the machine leaves it on the next clock edge.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the credit returns to zero (state code 00) and both `vend_o` and `change_o` are low after that edge. Any coin already inside the synchroniser is discarded.
- R2: A coin pulse sampled at clock edge n affects the outputs after edge n + SYNC_STAGES. This is edge n+2 with the default parameter.
- R3: A cycle with no coin leaves the credit unchanged, and no strobe results from it.
- R4: From zero credit (code 00), a one-unit coin moves the credit to one unit (code 01) and a two-unit coin moves it to two units (code 10). Neither coin raises any strobe.
- R5: From one unit of credit, a one-unit coin moves the credit to two units with no strobe. A two-unit coin fires vend without change and returns the credit to zero.
- R6: From two units of credit, a one-unit coin fires vend without change and a two-unit coin fires both vend and change. Both return the credit to zero.
- R7: If both coin inputs are high in the same cycle, the input is invalid. The credit is kept and no strobe results.
- R8: If the state register holds the unused code 11, the next edge moves it to zero credit with both strobes low, whatever the inputs are.
- R9: `vend_o` and `change_o` come from flip-flops and are each high for exactly one cycle per sale. `change_o` is never high without `vend_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| coin1_i | input | 1 | One-unit coin pulse, asynchronous |
| coin2_i | input | 1 | Two-unit coin pulse, asynchronous |
| vend_o | output | 1 | Registered one-cycle vend strobe |
| change_o | output | 1 | Registered one-cycle change strobe |

## Verification
A chained sequence of coins reaches every credit state through every entry path. For example, two units of credit are reached both from two one-unit coins and from a single two-unit coin. Each following coin then shows whether the credit was stored correctly. Exact-price and overpaid sales are told apart by whether `change_o` follows `vend_o`. Idle cycles and simultaneous coins are placed at non-zero credit, so that a design that drops or alters the credit gives a wrong strobe on the next coin. A reset taken at non-zero credit and a forced unused code are each followed by coins whose result depends on the credit having returned to zero.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int unsigned PRICE = 3;

  // Credit state codes; the numeric code equals the credit held.
  typedef enum logic [1:0] {
    CR_ZERO = 2'b00,
    CR_ONE  = 2'b01,
    CR_TWO  = 2'b10,
    CR_VOID = 2'b11
  } credit_e;

  typedef struct packed {
    credit_e nxt;
    logic    vend;
    logic    change;
  } step_t;

  // Credit arithmetic: add the coin value, sell when the price is reached.
  function automatic step_t vend_step(input credit_e cur, input logic c1, input logic c2);
    step_t      s;
    logic [2:0] total;
    s.nxt    = cur;
    s.vend   = 1'b0;
    s.change = 1'b0;
    total    = {1'b0, cur} + (c1 ? 3'd1 : 3'd2);
    if (cur == CR_VOID) begin
      s.nxt = CR_ZERO;
    end else if (c1 ^ c2) begin
      if (total >= 3'(PRICE)) begin
        s.nxt    = CR_ZERO;
        s.vend   = 1'b1;
        s.change = (total > 3'(PRICE));
      end else begin
        s.nxt = credit_e'(total[1:0]);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/coin_sync.sv
module coin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) pipe[g] <= '0;
        else       pipe[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i) begin
        if (rst_i) pipe[g] <= '0;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  credit_e cur_i,
  input  logic    c1_i,
  input  logic    c2_i,
  output step_t   step_o
);

  always_comb begin
    step_o = vend_step(cur_i, c1_i, c2_i);
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic coin1_i,
  input  logic coin2_i,
  output logic vend_o,
  output logic change_o
);

  logic [1:0] coin_s;
  logic       c1_s;
  logic       c2_s;
  credit_e    state_q;
  step_t      step;
  logic       vend_q;
  logic       change_q;

  coin_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  ({coin2_i, coin1_i}),
    .q_o  (coin_s)
  );

  assign c1_s = coin_s[0];
  assign c2_s = coin_s[1];

  vend_next u_next (
    .cur_i (state_q),
    .c1_i  (c1_s),
    .c2_i  (c2_s),
    .step_o(step)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= CR_ZERO;
      vend_q   <= 1'b0;
      change_q <= 1'b0;
    end else begin
      state_q  <= step.nxt;
      vend_q   <= step.vend;
      change_q <= step.change;
    end
  end

  assign vend_o   = vend_q;
  assign change_o = change_q;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       c1_s,
  input logic       c2_s,
  input logic [1:0] state_q,
  input logic       vend_o,
  input logic       change_o
);

  p_reset_idle_r1: assert property (@(posedge clk_i)
    rst_i |=> (state_q == 2'b00 && !vend_o && !change_o));

  p_no_coin_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!c1_s && !c2_s && state_q != 2'b11) |=> ($stable(state_q) && !vend_o));

  p_idle_no_sale_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == 2'b00) |=> !vend_o);

  p_both_coins_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (c1_s && c2_s && state_q != 2'b11) |=> ($stable(state_q) && !vend_o && !change_o));

  p_void_exit_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == 2'b11) |=> (state_q == 2'b00 && !vend_o && !change_o));

  p_change_needs_vend_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    change_o |-> vend_o);

  p_vend_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    vend_o |=> !vend_o);

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .c1_s    (c1_s),
  .c2_s    (c2_s),
  .state_q (state_q),
  .vend_o  (vend_o),
  .change_o(change_o)
);

// File: tb/vend_ctrl_tb_top.sv
module vend_ctrl_tb_top;
  import vend_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin1 = 1'b0;
  logic coin2 = 1'b0;
  logic vend;
  logic change;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #4 clk = ~clk;

  vend_ctrl dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .coin1_i (coin1),
    .coin2_i (coin2),
    .vend_o  (vend),
    .change_o(change)
  );

  // Rows: {coin1, coin2, expected vend, expected change}, chained from zero credit.
  localparam logic [3:0] VEC [18] = '{
    4'b1000, 4'b1000, 4'b1010,   // R4 1 -> R5 2 -> R6 sell exact
    4'b0100, 4'b0111,            // R4 two -> R6 sell with change
    4'b1000, 4'b0110,            // R5 two-unit coin sells exact
    4'b0100, 4'b0000, 4'b1010,   // R3 idle keeps two units
    4'b1000, 4'b1100, 4'b1000,   // R7 both at one unit, then to two
    4'b1100, 4'b0111,            // R7 both at two units, then overpay
    4'b0000, 4'b0100, 4'b1010    // R3 idle at zero
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: vend/change actual %b expected %b", req, act, exp);
    end
  endtask

  // Called at a negedge; returns the outputs one cycle and three cycles later.
  task automatic coin_step(input logic c1, input logic c2,
                           output logic [1:0] early, output logic [1:0] res);
    coin1 = c1;
    coin2 = c2;
    @(negedge clk);
    coin1 = 1'b0;
    coin2 = 1'b0;
    early = {vend, change};
    @(negedge clk);
    @(negedge clk);
    res = {vend, change};
  endtask

  task automatic final_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      final_report();
    end
  end

  initial begin
    logic [1:0] e;
    logic [1:0] r;
    repeat (3) @(negedge clk);
    check("R1 reset state", {vend, change}, 2'b00);
    rst = 1'b0;

    for (int i = 0; i < 18; i++) begin
      coin_step(VEC[i][3], VEC[i][2], e, r);
      check("R2 R9 no strobe before latency / single pulse", e, 2'b00);
      check($sformatf("R3-R7 vector %0d", i), r, VEC[i][1:0]);
    end

    // R1: reset at two units of credit must clear it and any coin in flight.
    coin_step(1'b0, 1'b1, e, r);
    coin1 = 1'b1;
    rst   = 1'b1;
    @(negedge clk);
    coin1 = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 outputs low after reset", {vend, change}, 2'b00);
    coin_step(1'b1, 1'b0, e, r);
    check("R1 credit cleared: one coin does not sell", r, 2'b00);
    coin_step(1'b0, 1'b1, e, r);
    check("R1 credit one plus two sells exact", r, 2'b10);

    // R8: unused code leaves to zero credit.
    force dut_i.state_q = CR_VOID;
    #1;
    release dut_i.state_q;
    @(negedge clk);
    check("R8 outputs low leaving unused code", {vend, change}, 2'b00);
    coin_step(1'b0, 1'b1, e, r);
    check("R8 two-unit coin after recovery gives no sale", r, 2'b00);
    coin_step(1'b1, 1'b0, e, r);
    check("R8 then one-unit coin sells exact", r, 2'b10);

    // R2: exact latency of a sale strobe.
    coin_step(1'b0, 1'b1, e, r);
    coin1 = 1'b1;
    @(negedge clk);
    coin1 = 1'b0;
    @(negedge clk);
    check("R2 no strobe after one edge of sync", {vend, change}, 2'b00);
    @(negedge clk);
    check("R2 strobe after SYNC_STAGES+1 edges", {vend, change}, 2'b10);
    @(negedge clk);
    check("R9 strobe lasts one cycle", {vend, change}, 2'b00);

    done = 1'b1;
    final_report();
  end

endmodule